// File: doc/BRIEF.md
# Commit-Ordered Store Issue Unit

This block buffers pending stores and sends them to a data-cache port strictly in program order. Every store enters as speculative. It stays that way until the retire path names its tag. Each cycle the unit looks at the oldest entries, up to a small issue budget. It issues them one after another and stops at the first one that is still speculative or whose address the cache cannot take. It never reaches past a blocked head to a younger store.

For each of the oldest few entries the unit presents the address on a probe lane, and the cache answers with one ready bit per lane. Every store that goes out becomes a store-kind request that carries its address, its tag and the current cycle number. The request leaves the queue at the same clock edge, and the unit marks its tag as in flight. The caller also gets the unused part of the budget for that cycle. The tag is the slot index the store was written into, and the unit returns it at enqueue time so that the retire logic can name the store later.

Top module: `store_commit_issue`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), no request is valid, `inflight` is all zero and `budget_left` equals `budget_in`.
- R2: Tags are slot indices handed out in ascending order modulo 8, starting at 0 after reset and shown on `enq_tag` in the enqueue cycle. Probe lane k (bits k*32 upward) shows the address of the k-th oldest entry, and issued lanes carry the oldest entries in enqueue order.
- R3: The queue holds 8 stores. While it holds 8, `q_full`=1 and `enq_ready`=0, and a store offered then is not taken and leaves the queue contents unchanged.
- R4: A store enters as speculative. It can issue only in a cycle after the edge that sampled `retire_valid` with its tag. A speculative oldest store blocks every younger store, even retired ones.
- R5: When `probe_ready[k]` is 0, lane k and every lane after it issue nothing in that cycle.
- R6: At most `budget_in` stores issue in a cycle, and `budget_left` equals `budget_in` minus the number issued. A budget of 0 issues nothing.
- R7: The valid request lanes always start at lane 0 and have no gaps. `req_kind` is 2'b01 (store) when any lane is valid and 2'b00 otherwise.
- R8: `req_stamp` on an issued request equals the number of clock edges since reset was released. It reads 0 in the first cycle after release.
- R9: `inflight[t]` is set at the edge where the store with tag t issues, and it is cleared when a new store is written into slot t.
- R10: An issued store is removed at that edge, and `q_empty` rises once all stores are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer a new store |
| enq_addr | input | 32 | Physical address of the offered store |
| enq_ready | output | 1 | Store can be accepted this cycle |
| enq_tag | output | 3 | Tag the offered store will receive |
| q_full | output | 1 | Queue holds 8 stores |
| q_empty | output | 1 | Queue holds no stores |
| retire_valid | input | 1 | Clear the speculative mark of one store |
| retire_tag | input | 3 | Tag of the store that retires |
| budget_in | input | 2 | Issue budget for this cycle |
| probe_addr | output | 96 | Address of the k-th oldest entry on lane k |
| probe_ready | input | 3 | Cache can accept the address on lane k |
| req_valid | output | 3 | Lane k issues a store this cycle |
| req_kind | output | 2 | Access kind: 2'b01 store, 2'b00 idle |
| req_addr | output | 96 | Address of the issued store on lane k |
| req_tag | output | 9 | Tag of the issued store on lane k (3 bits per lane) |
| req_stamp | output | 16 | Cycle number stamped on this cycle's issues |
| budget_left | output | 2 | Budget not used this cycle |
| inflight | output | 8 | Per-tag mark of an issued store waiting on memory |

## Verification
The request lanes, `budget_left`, `req_kind` and the probe addresses are combinational. They are due in the same cycle as the budget and ready inputs. The bench drives inputs just after a rising edge and compares at the following falling edge. Enqueue, retire and issue take effect at the next rising edge, so the bench model applies them right after that falling-edge comparison. Their effects (a store becoming eligible, an entry leaving, a new `inflight` bit, the count seen in `q_full`/`q_empty`) are therefore compared one cycle later. The stamp is modelled as a counter that starts at 0 on the first falling edge after reset release and steps once per cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int SQ_DEPTH = 8;
    localparam int ADDR_W   = 32;
    localparam int BUD_W    = 2;
    localparam int STAMP_W  = 16;
    localparam int TAG_W    = $clog2(SQ_DEPTH);
    localparam int CNT_W    = $clog2(SQ_DEPTH + 1);
    localparam int LANES    = (1 << BUD_W) - 1;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t addr;
        logic  spec;
    } sq_entry_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_STORE = 2'b01
    } acc_kind_e;

    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned depth);
        return (base + step) % depth;
    endfunction

endpackage

// File: rtl/sq_ring.sv
module sq_ring
    import sq_pkg::*;
#(
    parameter int NSLOT = SQ_DEPTH,
    parameter int NLANE = LANES,
    parameter int PW    = BUD_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enq_valid,
    input  addr_t                       enq_addr,
    output logic                        enq_ready,
    output logic [$clog2(NSLOT)-1:0]    enq_tag,
    output logic                        q_full,
    output logic                        q_empty,
    input  logic                        retire_valid,
    input  logic [$clog2(NSLOT)-1:0]    retire_tag,
    input  logic [PW-1:0]               pop_cnt,
    output sq_entry_t [NLANE-1:0]       lane_entry,
    output logic [NLANE-1:0][$clog2(NSLOT)-1:0] lane_tag,
    output logic [NLANE-1:0]            lane_live
);

    localparam int IW = $clog2(NSLOT);
    localparam int CW = $clog2(NSLOT + 1);

    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    sq_entry_t     mem_q [NSLOT];
    logic          enq_fire;

    assign q_full    = (cnt_q == CW'(NSLOT));
    assign q_empty   = (cnt_q == '0);
    assign enq_ready = !q_full;
    assign enq_fire  = enq_valid && !q_full;
    assign enq_tag   = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                mem_q[i] <= '{addr: '0, spec: 1'b1};
            end
        end else begin
            if (retire_valid) begin
                mem_q[retire_tag].spec <= 1'b0;
            end
            if (enq_fire) begin
                mem_q[tail_q] <= '{addr: enq_addr, spec: 1'b1};
                tail_q        <= IW'(ring_add(int'(tail_q), 1, NSLOT));
            end
            head_q <= IW'(ring_add(int'(head_q), int'(pop_cnt), NSLOT));
            cnt_q  <= cnt_q + CW'(enq_fire) - CW'(pop_cnt);
        end
    end

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign lane_tag[k]   = IW'(ring_add(int'(head_q), k, NSLOT));
        assign lane_entry[k] = mem_q[lane_tag[k]];
        assign lane_live[k]  = (cnt_q > CW'(k));
    end

endmodule

// File: rtl/sq_issue_sel.sv
module sq_issue_sel
    import sq_pkg::*;
#(
    parameter int NLANE = LANES,
    parameter int PW    = BUD_W
) (
    input  logic [PW-1:0]    budget,
    input  logic [NLANE-1:0] lane_live,
    input  logic [NLANE-1:0] lane_spec,
    input  logic [NLANE-1:0] probe_ready,
    output logic [NLANE-1:0] go,
    output logic [PW-1:0]    n_issue
);

    always_comb begin
        logic open;
        int   n;
        open = 1'b1;
        n    = 0;
        for (int k = 0; k < NLANE; k++) begin
            go[k] = open && lane_live[k] && !lane_spec[k] && probe_ready[k]
                    && (k < int'(budget));
            open  = go[k];
            n     = n + int'(go[k]);
        end
        n_issue = PW'(n);
    end

endmodule

// File: rtl/sq_stamp_ctr.sv
module sq_stamp_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] stamp
);

    always_ff @(posedge clk) begin
        if (rst) stamp <= '0;
        else     stamp <= stamp + W'(1);
    end

endmodule

// File: rtl/store_commit_issue.sv
module store_commit_issue
    import sq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enq_valid,
    input  logic [ADDR_W-1:0]         enq_addr,
    output logic                      enq_ready,
    output logic [TAG_W-1:0]          enq_tag,
    output logic                      q_full,
    output logic                      q_empty,
    input  logic                      retire_valid,
    input  logic [TAG_W-1:0]          retire_tag,
    input  logic [BUD_W-1:0]          budget_in,
    output logic [LANES*ADDR_W-1:0]   probe_addr,
    input  logic [LANES-1:0]          probe_ready,
    output logic [LANES-1:0]          req_valid,
    output logic [1:0]                req_kind,
    output logic [LANES*ADDR_W-1:0]   req_addr,
    output logic [LANES*TAG_W-1:0]    req_tag,
    output logic [STAMP_W-1:0]        req_stamp,
    output logic [BUD_W-1:0]          budget_left,
    output logic [SQ_DEPTH-1:0]       inflight
);

    sq_entry_t [LANES-1:0]            lane_entry;
    logic [LANES-1:0][TAG_W-1:0]      lane_tag;
    logic [LANES-1:0]                 lane_live;
    logic [LANES-1:0]                 lane_spec;
    logic [LANES-1:0]                 go;
    logic [BUD_W-1:0]                 n_issue;
    logic [SQ_DEPTH-1:0]              inflight_q, inflight_d;
    acc_kind_e                        kind;

    sq_ring #(.NSLOT(SQ_DEPTH), .NLANE(LANES), .PW(BUD_W)) ring_i (
        .clk          (clk),
        .rst          (rst),
        .enq_valid    (enq_valid),
        .enq_addr     (enq_addr),
        .enq_ready    (enq_ready),
        .enq_tag      (enq_tag),
        .q_full       (q_full),
        .q_empty      (q_empty),
        .retire_valid (retire_valid),
        .retire_tag   (retire_tag),
        .pop_cnt      (n_issue),
        .lane_entry   (lane_entry),
        .lane_tag     (lane_tag),
        .lane_live    (lane_live)
    );

    sq_issue_sel #(.NLANE(LANES), .PW(BUD_W)) sel_i (
        .budget      (budget_in),
        .lane_live   (lane_live),
        .lane_spec   (lane_spec),
        .probe_ready (probe_ready),
        .go          (go),
        .n_issue     (n_issue)
    );

    sq_stamp_ctr #(.W(STAMP_W)) stamp_i (
        .clk   (clk),
        .rst   (rst),
        .stamp (req_stamp)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_out
        assign lane_spec[k]                  = lane_entry[k].spec;
        assign probe_addr[k*ADDR_W +: ADDR_W] = lane_entry[k].addr;
        assign req_addr[k*ADDR_W +: ADDR_W]   = go[k] ? lane_entry[k].addr : '0;
        assign req_tag[k*TAG_W +: TAG_W]      = go[k] ? lane_tag[k] : '0;
    end

    assign req_valid   = go;
    assign kind        = (|go) ? ACC_STORE : ACC_IDLE;
    assign req_kind    = kind;
    assign budget_left = budget_in - n_issue;

    always_comb begin
        inflight_d = inflight_q;
        if (enq_valid && enq_ready) inflight_d[enq_tag] = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if (go[k]) inflight_d[lane_tag[k]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) inflight_q <= '0;
        else     inflight_q <= inflight_d;
    end

    assign inflight = inflight_q;

endmodule

// File: rtl/sq_issue_chk.sv
module sq_issue_chk
    import sq_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    enq_valid,
    input logic                    enq_ready,
    input logic [TAG_W-1:0]        enq_tag,
    input logic                    q_full,
    input logic                    q_empty,
    input logic                    retire_valid,
    input logic [TAG_W-1:0]        retire_tag,
    input logic [BUD_W-1:0]        budget_in,
    input logic [LANES-1:0]        req_valid,
    input logic [LANES*TAG_W-1:0]  req_tag,
    input logic [STAMP_W-1:0]      req_stamp,
    input logic [BUD_W-1:0]        budget_left,
    input logic [SQ_DEPTH-1:0]     inflight
);

    logic [SQ_DEPTH-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else begin
            if (retire_valid) seen_q[retire_tag] <= 1'b1;
            if (enq_valid && enq_ready) seen_q[enq_tag] <= 1'b0;
        end
    end

    p_refuse_when_full_r3: assert property (@(posedge clk) disable iff (rst)
        q_full |-> !enq_ready);

    p_budget_cap_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(req_valid) <= int'(budget_in));

    p_budget_left_r6: assert property (@(posedge clk) disable iff (rst)
        int'(budget_left) + $countones(req_valid) == int'(budget_in));

    p_lanes_packed_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({1'b0, req_valid} + 1'b1));

    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> (req_valid == '0));

    p_stamp_steps_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid[0] && $past(req_valid[0]) && !$past(rst))
            |-> (req_stamp == $past(req_stamp) + STAMP_W'(1)));

    p_inflight_set_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid[0] |=> inflight[$past(req_tag[TAG_W-1:0])]);

    for (genvar k = 0; k < LANES; k++) begin : g_ret
        p_retired_first_r4: assert property (@(posedge clk) disable iff (rst)
            req_valid[k] |-> seen_q[req_tag[k*TAG_W +: TAG_W]]);
    end

endmodule

bind store_commit_issue sq_issue_chk chk_i (.*);

// File: tb/store_commit_issue_tb_top.sv
module store_commit_issue_tb_top;
    import sq_pkg::*;

    localparam int CLK_P = 10;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     enq_valid = 1'b0;
    logic [ADDR_W-1:0]        enq_addr = '0;
    logic                     enq_ready;
    logic [TAG_W-1:0]         enq_tag;
    logic                     q_full, q_empty;
    logic                     retire_valid = 1'b0;
    logic [TAG_W-1:0]         retire_tag = '0;
    logic [BUD_W-1:0]         budget_in = '0;
    logic [LANES*ADDR_W-1:0]  probe_addr;
    logic [LANES-1:0]         probe_ready = '0;
    logic [LANES-1:0]         req_valid;
    logic [1:0]               req_kind;
    logic [LANES*ADDR_W-1:0]  req_addr;
    logic [LANES*TAG_W-1:0]   req_tag;
    logic [STAMP_W-1:0]       req_stamp;
    logic [BUD_W-1:0]         budget_left;
    logic [SQ_DEPTH-1:0]      inflight;

    always #(CLK_P/2) clk = ~clk;

    store_commit_issue dut_i (.*);

    typedef struct {
        logic [ADDR_W-1:0] a;
        int                t;
        bit                r;
    } item_t;

    item_t             mq[$];
    item_t             pend;
    bit                pend_v = 0;
    int                tail_m = 0;
    logic [SQ_DEPTH-1:0] infl_m = '0;
    int                cyc = 0;
    int                checks = 0, fails = 0;
    bit                done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus, pushes the expected enqueued item
    task automatic step(input bit ev, input logic [ADDR_W-1:0] ea, input bit rv,
                        input int rt, input int bud, input logic [LANES-1:0] rdy);
        @(posedge clk); #1;
        enq_valid    = ev;
        enq_addr     = ea;
        retire_valid = rv;
        retire_tag   = TAG_W'(rt);
        budget_in    = BUD_W'(bud);
        probe_ready  = rdy;
        pend_v = 0;
        if (ev && mq.size() < SQ_DEPTH) begin
            pend.a = ea; pend.t = tail_m; pend.r = 0;
            pend_v = 1;
            tail_m = (tail_m + 1) % SQ_DEPTH;
        end
    endtask

    // monitor: compare at falling edge, then advance the model to the next edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int n;
            n = 0;
            chk(enq_ready == (mq.size() < SQ_DEPTH), "R3 enq_ready", enq_ready, mq.size() < SQ_DEPTH);
            chk(q_full == (mq.size() == SQ_DEPTH), "R3 q_full", q_full, mq.size() == SQ_DEPTH);
            chk(q_empty == (mq.size() == 0), "R10 q_empty", q_empty, mq.size() == 0);
            for (int k = 0; k < LANES; k++) begin
                if (n == k && k < int'(budget_in) && k < mq.size() && mq[k].r && probe_ready[k])
                    n++;
            end
            for (int k = 0; k < LANES; k++) begin
                chk(req_valid[k] == (k < n), "R4/R5/R6 req_valid lane", req_valid, n);
                if (k < mq.size())
                    chk(probe_addr[k*ADDR_W +: ADDR_W] == mq[k].a, "R2 probe_addr",
                        probe_addr[k*ADDR_W +: ADDR_W], mq[k].a);
                if (k < n) begin
                    chk(req_addr[k*ADDR_W +: ADDR_W] == mq[k].a, "R2 req_addr",
                        req_addr[k*ADDR_W +: ADDR_W], mq[k].a);
                    chk(int'(req_tag[k*TAG_W +: TAG_W]) == mq[k].t, "R2 req_tag",
                        req_tag[k*TAG_W +: TAG_W], mq[k].t);
                    chk(int'(req_stamp) == cyc, "R8 req_stamp", req_stamp, cyc);
                end
            end
            chk(int'(budget_left) == int'(budget_in) - n, "R6 budget_left", budget_left, int'(budget_in) - n);
            chk(req_kind == ((n > 0) ? 2'b01 : 2'b00), "R7 req_kind", req_kind, (n > 0) ? 1 : 0);
            chk(inflight == infl_m, "R9 inflight", inflight, infl_m);
            if (pend_v) chk(int'(enq_tag) == pend.t, "R2 enq_tag", enq_tag, pend.t);
            // advance model to the state after the next rising edge
            for (int k = 0; k < n; k++) begin
                infl_m[mq[0].t] = 1'b1;
                void'(mq.pop_front());
            end
            if (retire_valid) begin
                foreach (mq[i]) if (mq[i].t == int'(retire_tag)) mq[i].r = 1;
            end
            if (pend_v) begin
                infl_m[pend.t] = 1'b0;
                mq.push_back(pend);
                pend_v = 0;
            end
            cyc = (cyc + 1) % (1 << STAMP_W);
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        budget_in = 2'd3;
        @(negedge clk);
        // R1 reset state
        chk(q_empty && !q_full, "R1 empty after reset", {q_full, q_empty}, 2'b01);
        chk(req_valid == '0, "R1 no request", req_valid, 0);
        chk(inflight == '0, "R1 inflight clear", inflight, 0);
        chk(budget_left == 2'd3, "R1 budget_left", budget_left, 3);

        // R4: speculative stores never issue
        step(1, 32'h1000, 0, 0, 3, 3'b111);
        step(1, 32'h1040, 0, 0, 3, 3'b111);
        step(1, 32'h1080, 0, 0, 3, 3'b111);
        step(0, 0, 0, 0, 3, 3'b111);
        // R4: younger retired first still blocked by head
        step(0, 0, 1, 1, 3, 3'b111);
        step(0, 0, 0, 0, 3, 3'b111);
        step(0, 0, 1, 0, 3, 3'b111);
        step(0, 0, 0, 0, 3, 3'b111);   // tags 0,1 issue here
        step(0, 0, 1, 2, 3, 3'b111);
        step(0, 0, 0, 0, 3, 3'b111);   // tag 2 issues, R10 empty after
        step(0, 0, 0, 0, 3, 3'b111);

        // R5: cache blocks head, then lane 1
        for (int i = 0; i < 4; i++) step(1, 32'h2000 + 32'(i * 64), 0, 0, 0, 3'b000);
        for (int i = 0; i < 4; i++) step(0, 0, 1, (3 + i) % SQ_DEPTH, 0, 3'b000);
        step(0, 0, 0, 0, 3, 3'b110);
        step(0, 0, 0, 0, 3, 3'b101);
        // R6: budgets 0, 1, 2
        step(0, 0, 0, 0, 0, 3'b111);
        step(0, 0, 0, 0, 1, 3'b111);
        step(0, 0, 0, 0, 2, 3'b111);
        step(0, 0, 0, 0, 3, 3'b111);

        // R3: fill to 8 and offer more while full; tags wrap past 7
        for (int i = 0; i < 10; i++) step(1, 32'h3000 + 32'(i * 64), 0, 0, 0, 3'b111);
        for (int i = 0; i < 8; i++) step(0, 0, 1, (7 + i) % SQ_DEPTH, 0, 3'b111);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 3, 3'b111);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            bit rv; int rt;
            rv = ($urandom % 2) == 0 && mq.size() > 0;
            rt = rv ? mq[$urandom % mq.size()].t : 0;
            step(($urandom % 3) != 0, $urandom, rv, rt, $urandom % 4, 3'($urandom));
        end
        for (int i = 0; i < 8; i++) step(0, 0, 1, i, 3, 3'b111);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 3, 3'b111);

        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule